// File: doc/BRIEF.md
# Power Mode and Clock Gating Controller

This block selects one of three power modes for a processor subsystem and turns that choice into clock-enable and PLL/oscillator enable levels. The core raises a one-cycle wait or stop request. The block acts on that request only if software has allowed that kind of request in the control register. Any wakeup source that software has enabled brings the block back to Run. A separate register holds one clock-enable bit for each peripheral, so software can switch off peripherals it does not use.

Stop can be shallow or deep. In a shallow stop the PLL and oscillator keep running, so the restart is immediate. In a deep stop both are powered down to save more power. On wakeup from a deep stop, the clocks stay gated until the PLL reports lock or a fixed settle window runs out. All outputs are enable levels that are meant to drive external glitch-free gating cells. The asynchronous reset is released synchronously inside the block.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is in Run, `mode_status` reads 00, and every peripheral enable bit is 1. The status codes are 00 Run, 01 Wait and 10 Stop, and 11 never appears.
- R2: In Run, `core_clk_en`, `sys_clk_en`, `pll_en` and `osc_en` are all 1, and `periph_clk_en` equals the peripheral register.
- R3: When control bit 0 (wait allow) is set, a `wait_req` in Run moves the block to Wait on the next clock edge. In Wait, core and system clocks are 0, `periph_clk_en` follows the peripheral register, and the PLL and oscillator stay on.
- R4: When control bit 1 (stop allow) is set, a `stop_req` in Run moves the block to Stop on the next edge. In Stop, core, system and all peripheral clock enables are 0.
- R5: A request whose allow bit is clear leaves the block in Run. A wait or stop request that arrives while the block is already in Wait or Stop has no effect.
- R6: When wait and stop are requested in the same cycle and both are allowed, the block enters Stop.
- R7: If control bit 2 (deep stop) was clear at Stop entry, `pll_en` and `osc_en` stay 1 during Stop, and an enabled wakeup returns the block to Run on the next edge.
- R8: If control bit 2 was set at Stop entry, `pll_en` and `osc_en` are 0 during Stop. Changing bit 2 while stopped does not alter the current stop.
- R9: A wakeup source counts only when its bit in the wake-enable register is 1. An enabled wakeup in Wait returns the block to Run on the next edge, and a masked wakeup leaves it in Wait.
- R10: An enabled wakeup from a deep stop starts a settle phase. During this phase the status reads 10, clocks stay gated, and `pll_en` and `osc_en` are 1. The block returns to Run on the edge where `pll_lock` is sampled high, or on the 64th edge of the settle phase.
- R11: Writes go to address 0 (control), address 1 (peripheral enables, bit i for peripheral i) or address 2 (wake enables, bit i for source i). A write takes effect on the same edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Register write data |
| wait_req | input | 1 | Core wait request strobe |
| stop_req | input | 1 | Core stop request strobe |
| wake_src | input | 4 | Wakeup / interrupt sources |
| pll_lock | input | 1 | PLL lock / settle indication |
| mode_status | output | 2 | Current mode code |
| core_clk_en | output | 1 | Core clock enable |
| sys_clk_en | output | 1 | System clock enable |
| periph_clk_en | output | 8 | Per-peripheral clock enables |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Oscillator enable |

## Verification
The assertions assume that the request strobes, wakeup sources and `pll_lock` are synchronous to `clk` and stable around the rising edge. They also assume that `pll_lock` matters only during the settle phase. The bench changes every input just after a falling edge and clears each strobe again after one clock, so every request lasts exactly one cycle. It raises `pll_lock` only in the cycle where it tests an early exit from settling.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_WAIT = 2'b01,
    MODE_STOP = 2'b10
  } mode_e;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_WAIT   = 2'd1,
    ST_STOP   = 2'd2,
    ST_SETTLE = 2'd3
  } state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PCLK = 2'd1;
  localparam logic [1:0] ADDR_WAKE = 2'd2;

  localparam int CTRL_WAIT_OK = 0;
  localparam int CTRL_STOP_OK = 1;
  localparam int CTRL_DEEP    = 2;
endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/pwr_cfg_regs.sv
module pwr_cfg_regs
  import pwr_mode_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int NUM_PERIPH = 8,
  parameter int NUM_WAKE   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic                  wait_allow,
  output logic                  stop_allow,
  output logic                  stop_deep,
  output logic [NUM_PERIPH-1:0] periph_on,
  output logic [NUM_WAKE-1:0]   wake_en
);
  logic [2:0]            ctrl_q, ctrl_d;
  logic [NUM_PERIPH-1:0] pclk_q, pclk_d;
  logic [NUM_WAKE-1:0]   wake_q, wake_d;
  logic                  ctrl_we, pclk_we, wake_we;
  logic                  unused_wr_bits;

  assign unused_wr_bits = ^wr_data;

  always_comb begin
    ctrl_we = wr_en && (wr_addr == ADDR_CTRL);
    pclk_we = wr_en && (wr_addr == ADDR_PCLK);
    wake_we = wr_en && (wr_addr == ADDR_WAKE);
    ctrl_d  = wr_data[2:0];
    pclk_d  = wr_data[NUM_PERIPH-1:0];
    wake_d  = wr_data[NUM_WAKE-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pclk_q <= '1;
      wake_q <= '1;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (pclk_we) pclk_q <= pclk_d;
      if (wake_we) wake_q <= wake_d;
    end
  end

  assign wait_allow = ctrl_q[CTRL_WAIT_OK];
  assign stop_allow = ctrl_q[CTRL_STOP_OK];
  assign stop_deep  = ctrl_q[CTRL_DEEP];
  assign periph_on  = pclk_q;
  assign wake_en    = wake_q;
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int NUM_WAKE      = 4,
  parameter int SETTLE_CYCLES = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wait_req,
  input  logic                stop_req,
  input  logic                wait_allow,
  input  logic                stop_allow,
  input  logic                stop_deep,
  input  logic [NUM_WAKE-1:0] wake_src,
  input  logic [NUM_WAKE-1:0] wake_en,
  input  logic                pll_lock,
  output state_e              state,
  output logic                deep_active
);
  localparam int CNT_W = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  state_e           st_q, st_d;
  logic             deep_q, deep_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en, wake_hit;

  assign wake_hit = |(wake_src & wake_en);

  always_comb begin
    st_d   = st_q;
    deep_d = deep_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (stop_req && stop_allow) begin
          st_d   = ST_STOP;
          deep_d = stop_deep;
        end else if (wait_req && wait_allow) begin
          st_d = ST_WAIT;
        end
      end
      ST_WAIT: if (wake_hit) st_d = ST_RUN;
      ST_STOP: begin
        if (wake_hit) begin
          if (deep_q) begin
            st_d   = ST_SETTLE;
            cnt_d  = '0;
            cnt_en = 1'b1;
          end else begin
            st_d = ST_RUN;
          end
        end
      end
      ST_SETTLE: begin
        if (pll_lock || (cnt_q == CNT_LAST)) begin
          st_d   = ST_RUN;
          deep_d = 1'b0;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      deep_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      deep_q <= deep_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign state       = st_q;
  assign deep_active = deep_q;
endmodule

// File: rtl/pwr_gate_decode.sv
module pwr_gate_decode
  import pwr_mode_pkg::*;
#(
  parameter int NUM_PERIPH = 8
) (
  input  state_e                state,
  input  logic                  deep_active,
  input  logic [NUM_PERIPH-1:0] periph_on,
  output logic [1:0]            mode_status,
  output logic                  core_clk_en,
  output logic                  sys_clk_en,
  output logic [NUM_PERIPH-1:0] periph_clk_en,
  output logic                  pll_en,
  output logic                  osc_en
);
  always_comb begin
    mode_status   = MODE_RUN;
    core_clk_en   = 1'b1;
    sys_clk_en    = 1'b1;
    periph_clk_en = periph_on;
    pll_en        = 1'b1;
    osc_en        = 1'b1;
    unique case (state)
      ST_RUN: ;
      ST_WAIT: begin
        mode_status = MODE_WAIT;
        core_clk_en = 1'b0;
        sys_clk_en  = 1'b0;
      end
      ST_STOP: begin
        mode_status   = MODE_STOP;
        core_clk_en   = 1'b0;
        sys_clk_en    = 1'b0;
        periph_clk_en = '0;
        pll_en        = !deep_active;
        osc_en        = !deep_active;
      end
      ST_SETTLE: begin
        mode_status   = MODE_STOP;
        core_clk_en   = 1'b0;
        sys_clk_en    = 1'b0;
        periph_clk_en = '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int NUM_PERIPH    = 8,
  parameter int NUM_WAKE      = 4,
  parameter int SETTLE_CYCLES = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  wait_req,
  input  logic                  stop_req,
  input  logic [NUM_WAKE-1:0]   wake_src,
  input  logic                  pll_lock,
  output logic [1:0]            mode_status,
  output logic                  core_clk_en,
  output logic                  sys_clk_en,
  output logic [NUM_PERIPH-1:0] periph_clk_en,
  output logic                  pll_en,
  output logic                  osc_en
);
  logic                  rst_sync_n;
  logic                  wait_allow, stop_allow, stop_deep, deep_active;
  logic [NUM_PERIPH-1:0] periph_on;
  logic [NUM_WAKE-1:0]   wake_en;
  state_e                state;
  logic                  in_settle;

  pwr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwr_cfg_regs #(
    .DATA_W     (DATA_W),
    .NUM_PERIPH (NUM_PERIPH),
    .NUM_WAKE   (NUM_WAKE)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wait_allow (wait_allow),
    .stop_allow (stop_allow),
    .stop_deep  (stop_deep),
    .periph_on  (periph_on),
    .wake_en    (wake_en)
  );

  pwr_mode_fsm #(
    .NUM_WAKE      (NUM_WAKE),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wait_req    (wait_req),
    .stop_req    (stop_req),
    .wait_allow  (wait_allow),
    .stop_allow  (stop_allow),
    .stop_deep   (stop_deep),
    .wake_src    (wake_src),
    .wake_en     (wake_en),
    .pll_lock    (pll_lock),
    .state       (state),
    .deep_active (deep_active)
  );

  assign in_settle = (state == ST_SETTLE);

  pwr_gate_decode #(
    .NUM_PERIPH (NUM_PERIPH)
  ) u_dec (
    .state         (state),
    .deep_active   (deep_active),
    .periph_on     (periph_on),
    .mode_status   (mode_status),
    .core_clk_en   (core_clk_en),
    .sys_clk_en    (sys_clk_en),
    .periph_clk_en (periph_clk_en),
    .pll_en        (pll_en),
    .osc_en        (osc_en)
  );
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int NUM_PERIPH = 8,
  parameter int NUM_WAKE   = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wait_req,
  input logic                  stop_req,
  input logic                  wait_allow,
  input logic                  stop_allow,
  input logic [NUM_WAKE-1:0]   wake_src,
  input logic [NUM_WAKE-1:0]   wake_en,
  input logic                  pll_lock,
  input logic                  in_settle,
  input logic [1:0]            mode_status,
  input logic                  core_clk_en,
  input logic                  sys_clk_en,
  input logic [NUM_PERIPH-1:0] periph_clk_en,
  input logic                  pll_en,
  input logic                  osc_en
);
  p_status_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_status != 2'b11);

  p_run_clocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_status == 2'b00) |-> (core_clk_en && sys_clk_en && pll_en && osc_en));

  p_core_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_status != 2'b00) |-> (!core_clk_en && !sys_clk_en));

  p_stop_periph_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_status == 2'b10) |-> (periph_clk_en == '0));

  p_blocked_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_status == 2'b00) && wait_req && !wait_allow && !stop_req) |=> (mode_status == 2'b00));

  p_both_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_status == 2'b00) && wait_req && wait_allow && stop_req && stop_allow) |=> (mode_status == 2'b10));

  p_deep_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en == osc_en);

  p_wait_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_status == 2'b01) && |(wake_src & wake_en)) |=> (mode_status == 2'b00));

  p_lock_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_settle && pll_lock) |=> (mode_status == 2'b00));

  p_settle_osc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_settle |-> (pll_en && osc_en && (mode_status == 2'b10)));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(
  .NUM_PERIPH (NUM_PERIPH),
  .NUM_WAKE   (NUM_WAKE)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .wait_req      (wait_req),
  .stop_req      (stop_req),
  .wait_allow    (wait_allow),
  .stop_allow    (stop_allow),
  .wake_src      (wake_src),
  .wake_en       (wake_en),
  .pll_lock      (pll_lock),
  .in_settle     (in_settle),
  .mode_status   (mode_status),
  .core_clk_en   (core_clk_en),
  .sys_clk_en    (sys_clk_en),
  .periph_clk_en (periph_clk_en),
  .pll_en        (pll_en),
  .osc_en        (osc_en)
);

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/100ps
module pwr_mode_ctrl_test;
  localparam int NP = 8;
  localparam int NW = 4;

  typedef struct packed {
    logic [1:0]    mode;
    logic          core;
    logic          sys;
    logic          pll;
    logic          osc;
    logic [NP-1:0] per;
  } exp_t;

  localparam int K_RUN = 0, K_WAIT = 1, K_STOP = 2, K_DEEP = 3, K_SETTLE = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, wait_req, stop_req, pll_lock;
  logic [1:0]    wr_addr;
  logic [15:0]   wr_data;
  logic [NW-1:0] wake_src;
  logic [1:0]    mode_status;
  logic          core_clk_en, sys_clk_en, pll_en, osc_en;
  logic [NP-1:0] periph_clk_en;

  int     checks = 0;
  int     errors = 0;
  bit     done = 1'b0;
  exp_t   q[$];
  string  tq[$];
  logic [NP-1:0] per_model;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wait_req(wait_req), .stop_req(stop_req), .wake_src(wake_src), .pll_lock(pll_lock),
    .mode_status(mode_status), .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en),
    .periph_clk_en(periph_clk_en), .pll_en(pll_en), .osc_en(osc_en)
  );

  function automatic exp_t mk(input int k);
    exp_t e;
    e.mode = 2'b00; e.core = 1'b1; e.sys = 1'b1; e.pll = 1'b1; e.osc = 1'b1; e.per = per_model;
    if (k == K_WAIT) begin
      e.mode = 2'b01; e.core = 1'b0; e.sys = 1'b0;
    end else if (k != K_RUN) begin
      e.mode = 2'b10; e.core = 1'b0; e.sys = 1'b0; e.per = '0;
      if (k == K_DEEP) begin e.pll = 1'b0; e.osc = 1'b0; end
    end
    return e;
  endfunction

  task automatic step(input int k, input string tag);
    @(posedge clk);
    q.push_back(mk(k));
    tq.push_back(tag);
    @(negedge clk);
    wr_en = 1'b0; wait_req = 1'b0; stop_req = 1'b0; wake_src = '0; pll_lock = 1'b0;
  endtask

  task automatic write(input logic [1:0] a, input logic [15:0] d, input int k, input string tag);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (a == 2'd1) per_model = d[NP-1:0];
    step(k, tag);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t  e;
      exp_t  a;
      string t;
      e = q.pop_front();
      t = tq.pop_front();
      a = {mode_status, core_clk_en, sys_clk_en, pll_en, osc_en, periph_clk_en};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: actual mode=%b core=%b sys=%b pll=%b osc=%b per=%h expected mode=%b core=%b sys=%b pll=%b osc=%b per=%h",
                 t, a.mode, a.core, a.sys, a.pll, a.osc, a.per,
                 e.mode, e.core, e.sys, e.pll, e.osc, e.per);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    wait_req = 1'b0; stop_req = 1'b0; wake_src = '0; pll_lock = 1'b0;
    per_model = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    step(K_RUN, "R1 reset state");
    step(K_RUN, "R2 run clocks");
    wait_req = 1'b1; step(K_RUN, "R5 wait blocked");
    stop_req = 1'b1; step(K_RUN, "R5 stop blocked");
    write(2'd1, 16'h00A5, K_RUN, "R11 periph write");
    write(2'd0, 16'h0003, K_RUN, "R11 ctrl write");
    wait_req = 1'b1; step(K_WAIT, "R3 enter wait");
    step(K_WAIT, "R3 hold wait");
    stop_req = 1'b1; step(K_WAIT, "R5 stop ignored in wait");
    write(2'd2, 16'h0002, K_WAIT, "R11 wake enable write");
    wake_src = 4'b0001; step(K_WAIT, "R9 masked wake");
    wake_src = 4'b0010; step(K_RUN, "R9 enabled wake");
    wait_req = 1'b1; stop_req = 1'b1; step(K_STOP, "R6 both requests");
    step(K_STOP, "R7 shallow stop keeps pll");
    wait_req = 1'b1; step(K_STOP, "R5 wait ignored in stop");
    wake_src = 4'b0010; step(K_RUN, "R7 shallow wake");
    write(2'd0, 16'h0007, K_RUN, "R11 ctrl deep");
    stop_req = 1'b1; step(K_DEEP, "R8 deep stop");
    write(2'd0, 16'h0003, K_DEEP, "R8 deep latched");
    wake_src = 4'b0010; step(K_SETTLE, "R10 settle start");
    step(K_SETTLE, "R10 settle hold");
    pll_lock = 1'b1; step(K_RUN, "R10 lock exit");
    write(2'd0, 16'h0007, K_RUN, "R11 ctrl deep again");
    stop_req = 1'b1; step(K_DEEP, "R4 deep stop gates");
    wake_src = 4'b0010; step(K_SETTLE, "R10 settle count start");
    for (int i = 0; i < 63; i++) step(K_SETTLE, "R10 settle counting");
    step(K_RUN, "R10 settle timeout");
    write(2'd1, 16'h003C, K_RUN, "R11 periph rewrite");
    wait_req = 1'b1; step(K_WAIT, "R3 wait keeps periph");
    wake_src = 4'b0010; step(K_RUN, "R9 wake again");

    @(negedge clk);
    #1;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule